// File: doc/BRIEF.md
# Ethernet receive address filter

This block makes the accept-or-drop decision for each received Ethernet frame based on its 48-bit destination address. It serves two MAC interfaces. Each interface has its own control register, its own unicast station address, a multicast table of up to four entries with a valid bit per entry, and its own promiscuous setting. The receive path presents a destination address together with a strobe and an interface select. One clock later the block returns a registered decision, tagged with the interface it belongs to.

Software programs the filter through a small write port. A 2-bit operation code chooses one of four targets: the control bits, the unicast address, a table-entry write, or a table-entry clear. Two reject bits in the control register take priority over both the table and promiscuous mode. A multicast reject blocks all group traffic but leaves the table contents in place. A broadcast reject is the only setting that can drop the all-ones address. A reset-request bit in either interface's control register starts a fixed-length reset pulse on a shared MAC reset output. While the pulse is active, every decision is a drop.

Top module: `rx_addr_filter`

## Requirements
- R1: When `addr_valid_i` is high at a rising edge, `dec_valid_o` goes high for one cycle after that edge. In that cycle `dec_if_o` equals the sampled `addr_if_i`. `dec_valid_o` is low in every other cycle, and `dec_accept_o` is high only while `dec_valid_o` is high.
- R2: Address octet 0 sits in `addr_i[47:40]`. With promiscuous mode off, a unicast destination (`addr_i[40]`=0) is accepted only when it exactly equals the interface's unicast address. That address is written with op 1 (`wr_data_i[47:0]`).
- R3: A destination is multicast when `addr_i[40]`=1 and the address is not all-ones. Op 2 writes `wr_data_i` into table entry `wr_idx_i` (0 to 3) and sets that entry's valid bit. With promiscuous mode off, a multicast destination is accepted only when it matches a valid entry.
- R4: Op 3 clears the valid bit of table entry `wr_idx_i`. The matching destination is then dropped, and the other entries keep matching.
- R5: Control bit 1 (multicast reject) drops every multicast destination, even on a table hit and even with promiscuous mode on. Clearing the bit restores acceptance of the stored entries without rewriting them.
- R6: Control bit 3 (promiscuous), with multicast reject off, accepts every unicast and multicast destination, including groups beyond the four table entries.
- R7: The all-ones address is accepted unless control bit 2 (broadcast reject) is set. With bit 2 set, it is dropped, whatever the promiscuous setting.
- R8: An op 0 write with `wr_data_i[0]`=1 to either interface raises `mac_rst_o` from the next cycle for exactly RST_CYCLES cycles (8 by default). After that, `mac_rst_o` returns low without further writes.
- R9: A decision whose strobe is sampled while `mac_rst_o` is high is a drop.
- R10: After `rst_n` the outputs are low and all control bits are 0. The table entries are invalid and the unicast address is zero, so broadcast is accepted and multicast is dropped.
- R11: The two interfaces are independent. Writes aimed at one interface (`wr_if_i`) do not change how the other one filters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_if_i | input | 1 | Interface targeted by the write |
| wr_op_i | input | 2 | 0 control, 1 unicast address, 2 table write, 3 table clear |
| wr_idx_i | input | 2 | Table entry index for ops 2 and 3 |
| wr_data_i | input | 48 | Write data; control uses bits 3:0 |
| addr_valid_i | input | 1 | Destination address strobe |
| addr_if_i | input | 1 | Interface that received the frame |
| addr_i | input | 48 | Destination address, octet 0 in bits 47:40 |
| dec_valid_o | output | 1 | Decision valid |
| dec_accept_o | output | 1 | 1 accept, 0 drop |
| dec_if_o | output | 1 | Interface tag of the decision |
| mac_rst_o | output | 1 | Shared MAC reset pulse |

## Verification
A register write takes effect at the rising edge where it is sampled, so the bench presents its next address one cycle later. A filter decision is due at the first rising edge after the strobe. The bench drives the strobe at a falling edge and reads the decision at the next falling edge, which is midway through the single cycle in which the decision is valid. The reset pulse starts at the edge that samples the control write. The bench counts falling-edge samples of `mac_rst_o` to confirm a length of exactly eight cycles, and it places a strobe inside the pulse to observe the forced drop.

// File: rtl/raf_pkg.sv
// Package: shared types for the receive address filter.
// Assumes octet 0 of a MAC address occupies bits [47:40].
package raf_pkg;
    localparam int MAC_AW = 48;

    typedef enum logic [1:0] {
        OP_CTRL   = 2'd0,
        OP_UCAST  = 2'd1,
        OP_MC_SET = 2'd2,
        OP_MC_CLR = 2'd3
    } raf_op_e;

    // Control bit positions within wr_data for OP_CTRL
    localparam int CTL_RST  = 0;
    localparam int CTL_MREJ = 1;
    localparam int CTL_BREJ = 2;
    localparam int CTL_PROM = 3;

    typedef struct packed {
        logic promisc;
        logic bc_rej;
        logic mc_rej;
    } raf_ctrl_t;
endpackage

// File: rtl/raf_if_regs.sv
// Module: per-interface filter state (control bits, unicast address,
// multicast table with valid bits). Assumes wr_hit qualifies the write
// for this interface only. The reset-request bit is not stored here.
module raf_if_regs #(
    parameter int AW    = 48,
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_hit,
    input  raf_pkg::raf_op_e          wr_op,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [AW-1:0]             wr_data,
    output raf_pkg::raf_ctrl_t        ctrl,
    output logic [AW-1:0]             ucast,
    output logic [DEPTH-1:0][AW-1:0]  mc_addr,
    output logic [DEPTH-1:0]          mc_vld
);
    import raf_pkg::*;

    // Control bits and unicast address update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            ucast <= '0;
        end else if (wr_hit) begin
            if (wr_op == OP_CTRL) begin
                ctrl.mc_rej  <= wr_data[CTL_MREJ];
                ctrl.bc_rej  <= wr_data[CTL_BREJ];
                ctrl.promisc <= wr_data[CTL_PROM];
            end
            if (wr_op == OP_UCAST) ucast <= wr_data;
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic sel;
        assign sel = wr_hit && (wr_idx == IDX_W'(e));

        // Table entry write sets valid, clear drops valid but keeps data
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mc_addr[e] <= '0;
                mc_vld[e]  <= 1'b0;
            end else if (sel && wr_op == OP_MC_SET) begin
                mc_addr[e] <= wr_data;
                mc_vld[e]  <= 1'b1;
            end else if (sel && wr_op == OP_MC_CLR) begin
                mc_vld[e]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/raf_match.sv
// Module: combinational accept decision for one interface.
// Assumes the all-ones address is broadcast only, never multicast.
// Reject bits take priority over the table and over promiscuous mode.
module raf_match #(
    parameter int AW    = 48,
    parameter int DEPTH = 4
) (
    input  logic [AW-1:0]             addr,
    input  raf_pkg::raf_ctrl_t        ctrl,
    input  logic [AW-1:0]             ucast,
    input  logic [DEPTH-1:0][AW-1:0]  mc_addr,
    input  logic [DEPTH-1:0]          mc_vld,
    output logic                      accept
);
    localparam int GRP_BIT = AW - 8;

    logic             is_bc;
    logic             is_mc;
    logic [DEPTH-1:0] ent_hit;

    assign is_bc = &addr;
    assign is_mc = addr[GRP_BIT] && !is_bc;

    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
        assign ent_hit[e] = mc_vld[e] && (mc_addr[e] == addr);
    end

    // Classify the destination and apply the matching policy
    always_comb begin
        if (is_bc)      accept = !ctrl.bc_rej;
        else if (is_mc) accept = !ctrl.mc_rej && (ctrl.promisc || (|ent_hit));
        else            accept = ctrl.promisc || (addr == ucast);
    end
endmodule

// File: rtl/raf_rst_pulse.sv
// Module: self-timed reset pulse generator. A request loads the counter;
// busy stays high for CYCLES cycles. A new request restarts the count.
module raf_rst_pulse #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Load on request, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (req)           cnt <= CNT_W'(CYCLES);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/rx_addr_filter.sv
// Module: two-interface Ethernet receive destination address filter.
// Assumes one address strobe per cycle at most; the decision is registered
// and tagged with the interface. A reset request from either interface
// drives the shared MAC reset pulse and forces drops while it lasts.
module rx_addr_filter #(
    parameter int AW         = 48,
    parameter int MC_DEPTH   = 4,
    parameter int RST_CYCLES = 8,
    localparam int IDX_W     = $clog2(MC_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_if_i,
    input  logic [1:0]       wr_op_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [AW-1:0]    wr_data_i,
    input  logic             addr_valid_i,
    input  logic             addr_if_i,
    input  logic [AW-1:0]    addr_i,
    output logic             dec_valid_o,
    output logic             dec_accept_o,
    output logic             dec_if_o,
    output logic             mac_rst_o
);
    import raf_pkg::*;

    localparam int NUM_IF = 2;

    raf_op_e          wr_op;
    logic [NUM_IF-1:0] if_accept;
    logic [NUM_IF-1:0] mc_rej_vec;
    logic [NUM_IF-1:0] bc_rej_vec;
    logic             rst_req;

    assign wr_op   = raf_op_e'(wr_op_i);
    assign rst_req = wr_en_i && (wr_op == OP_CTRL) && wr_data_i[CTL_RST];

    for (genvar g = 0; g < NUM_IF; g++) begin : g_if
        raf_ctrl_t                   ctrl;
        logic [AW-1:0]               ucast;
        logic [MC_DEPTH-1:0][AW-1:0] mc_addr;
        logic [MC_DEPTH-1:0]         mc_vld;
        logic                        wr_hit;

        assign wr_hit        = wr_en_i && (wr_if_i == 1'(g));
        assign mc_rej_vec[g] = ctrl.mc_rej;
        assign bc_rej_vec[g] = ctrl.bc_rej;

        raf_if_regs #(.AW(AW), .DEPTH(MC_DEPTH), .IDX_W(IDX_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit),
            .wr_op   (wr_op),
            .wr_idx  (wr_idx_i),
            .wr_data (wr_data_i),
            .ctrl    (ctrl),
            .ucast   (ucast),
            .mc_addr (mc_addr),
            .mc_vld  (mc_vld)
        );

        raf_match #(.AW(AW), .DEPTH(MC_DEPTH)) u_match (
            .addr    (addr_i),
            .ctrl    (ctrl),
            .ucast   (ucast),
            .mc_addr (mc_addr),
            .mc_vld  (mc_vld),
            .accept  (if_accept[g])
        );
    end

    raf_rst_pulse #(.CYCLES(RST_CYCLES)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rst_req),
        .busy  (mac_rst_o)
    );

    // Register the decision for the selected interface
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o  <= 1'b0;
            dec_accept_o <= 1'b0;
            dec_if_o     <= 1'b0;
        end else begin
            dec_valid_o  <= addr_valid_i;
            dec_accept_o <= addr_valid_i && !mac_rst_o && if_accept[addr_if_i];
            dec_if_o     <= addr_if_i;
        end
    end
endmodule

// File: rtl/raf_chk.sv
// Module: protocol checker for rx_addr_filter, attached with bind.
// Assumes it sees the per-interface reject bits of the filter.
module raf_chk #(
    parameter int AW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_i,
    input logic [1:0]    wr_op_i,
    input logic          wr_rst_bit,
    input logic          addr_valid_i,
    input logic          addr_if_i,
    input logic [AW-1:0] addr_i,
    input logic          dec_valid_o,
    input logic          dec_accept_o,
    input logic          dec_if_o,
    input logic          mac_rst_o,
    input logic [1:0]    mc_rej_vec,
    input logic [1:0]    bc_rej_vec
);
    logic chk_bc;
    logic chk_mc;
    assign chk_bc = (addr_i == {AW{1'b1}});
    assign chk_mc = addr_i[AW-8] && !chk_bc;

    // R1
    dec_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_i |=> dec_valid_o);
    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid_i |=> !dec_valid_o);
    // R1
    if_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_i |=> (dec_if_o == $past(addr_if_i)));
    // R1
    accept_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept_o |-> dec_valid_o);
    // R5
    mc_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && chk_mc && mc_rej_vec[addr_if_i]) |=> !dec_accept_o);
    // R7
    bc_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && chk_bc && bc_rej_vec[addr_if_i]) |=> !dec_accept_o);
    // R8
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_op_i == 2'd0 && wr_rst_bit) |=> mac_rst_o);
    // R9
    rst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && mac_rst_o) |=> !dec_accept_o);
endmodule

bind rx_addr_filter raf_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_op_i      (wr_op_i),
    .wr_rst_bit   (wr_data_i[0]),
    .addr_valid_i (addr_valid_i),
    .addr_if_i    (addr_if_i),
    .addr_i       (addr_i),
    .dec_valid_o  (dec_valid_o),
    .dec_accept_o (dec_accept_o),
    .dec_if_o     (dec_if_o),
    .mac_rst_o    (mac_rst_o),
    .mc_rej_vec   (mc_rej_vec),
    .bc_rej_vec   (bc_rej_vec)
);

// File: tb/rx_addr_filter_tb.sv
// Bench: vector table walk followed by directed reset and corner tests.
module rx_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_if_i = 1'b0;
    logic [1:0]  wr_op_i = 2'd0;
    logic [1:0]  wr_idx_i = 2'd0;
    logic [47:0] wr_data_i = '0;
    logic        addr_valid_i = 1'b0;
    logic        addr_if_i = 1'b0;
    logic [47:0] addr_i = '0;
    logic        dec_valid_o, dec_accept_o, dec_if_o, mac_rst_o;

    int checks = 0;
    int errors = 0;

    localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] UC0  = 48'h0200_0000_0001;
    localparam logic [47:0] UC1  = 48'h0A00_0000_0002;
    localparam logic [47:0] MCA  = 48'h0100_5E00_0001;
    localparam logic [47:0] MCB  = 48'h0100_5E00_007F;
    localparam logic [47:0] MCX  = 48'h0100_5E00_1234;

    // {interface, address, expected accept}
    localparam int NV = 10;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, UC0,               1'b1},  // R2 exact unicast
        {1'b0, 48'h0200_0000_0002, 1'b0}, // R2 near miss
        {1'b0, MCA,               1'b1},  // R3 entry 0
        {1'b0, MCB,               1'b1},  // R3 entry 3
        {1'b0, 48'h0100_5E00_0002, 1'b0}, // R3 miss
        {1'b0, BC,                1'b1},  // R7 broadcast allowed
        {1'b1, UC0,               1'b0},  // R11 other interface address
        {1'b1, UC1,               1'b1},  // R11 own address
        {1'b1, MCA,               1'b0},  // R11 separate table
        {1'b1, BC,                1'b0}   // R7 broadcast rejected
    };

    rx_addr_filter u_dut (.*);

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input logic ifx, input logic [1:0] op, input logic [1:0] idx,
                      input logic [47:0] data);
        wr_en_i = 1'b1; wr_if_i = ifx; wr_op_i = op; wr_idx_i = idx; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic probe(input logic ifx, input logic [47:0] a, input logic exp,
                         input string tag);
        addr_valid_i = 1'b1; addr_if_i = ifx; addr_i = a;
        @(negedge clk);
        addr_valid_i = 1'b0;
        check(tag, {47'd0, dec_accept_o}, {47'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 dec_valid", {47'd0, dec_valid_o}, 48'd0);
        check("R10 mac_rst", {47'd0, mac_rst_o}, 48'd0);
        probe(1'b0, BC, 1'b1, "R10 broadcast default");
        probe(1'b0, MCA, 1'b0, "R10 multicast default");
        probe(1'b1, UC0, 1'b0, "R10 unicast default");

        // R1 timing and tag
        addr_valid_i = 1'b1; addr_if_i = 1'b1; addr_i = BC;
        @(negedge clk);
        addr_valid_i = 1'b0;
        check("R1 valid", {47'd0, dec_valid_o}, 48'd1);
        check("R1 tag", {47'd0, dec_if_o}, 48'd1);
        @(negedge clk);
        check("R1 valid drops", {47'd0, dec_valid_o}, 48'd0);
        check("R1 accept drops", {47'd0, dec_accept_o}, 48'd0);

        // Setup for the table walk
        wr(1'b0, 2'd1, 2'd0, UC0);
        wr(1'b0, 2'd2, 2'd0, MCA);
        wr(1'b0, 2'd2, 2'd3, MCB);
        wr(1'b1, 2'd1, 2'd0, UC1);
        wr(1'b1, 2'd0, 2'd0, 48'h4);      // bc reject on interface 1
        for (int i = 0; i < NV; i++)
            probe(VEC[i][49], VEC[i][48:1], VEC[i][0], $sformatf("R2 R3 R7 R11 vector %0d", i));

        // R5 multicast reject overrides table and promiscuous mode
        wr(1'b0, 2'd0, 2'd0, 48'h2);
        probe(1'b0, MCB, 1'b0, "R5 reject hit");
        wr(1'b0, 2'd0, 2'd0, 48'hA);
        probe(1'b0, MCX, 1'b0, "R5 reject with promisc");
        probe(1'b0, 48'h0200_00AB_CDEF, 1'b1, "R6 promisc unicast");
        wr(1'b0, 2'd0, 2'd0, 48'h0);
        probe(1'b0, MCB, 1'b1, "R5 table kept");

        // R6 promiscuous accepts groups outside the table
        wr(1'b0, 2'd0, 2'd0, 48'h8);
        probe(1'b0, MCX, 1'b1, "R6 promisc multicast");
        // R7 broadcast reject wins over promiscuous
        wr(1'b0, 2'd0, 2'd0, 48'hC);
        probe(1'b0, BC, 1'b0, "R7 reject with promisc");
        wr(1'b0, 2'd0, 2'd0, 48'h0);

        // R4 clear entry 0, entry 3 unaffected
        wr(1'b0, 2'd3, 2'd0, 48'h0);
        probe(1'b0, MCA, 1'b0, "R4 cleared entry");
        probe(1'b0, MCB, 1'b1, "R4 other entry");

        // R8 pulse length from interface 1
        wr(1'b1, 2'd0, 2'd0, 48'h1);
        begin
            int n = 0;
            while (mac_rst_o && n < 40) begin
                n++;
                @(negedge clk);
            end
            check("R8 pulse length", 48'(n), 48'd8);
        end
        check("R8 self clear", {47'd0, mac_rst_o}, 48'd0);

        // R9 drop during pulse triggered from interface 0
        wr(1'b0, 2'd0, 2'd0, 48'h1);
        check("R8 either interface", {47'd0, mac_rst_o}, 48'd1);
        probe(1'b0, BC, 1'b0, "R9 drop in reset");
        repeat (10) @(negedge clk);
        probe(1'b0, BC, 1'b1, "R9 accept after pulse");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule